// File: doc/BRIEF.md
# Four-Stage Overlapped Instruction Pipeline

This block is the front end and execution path of a small in-order processor. Instructions flow through four stages that overlap: fetch, decode, operand read and execute. Each stage passes its work on at every clock edge while accepting new work. Once the pipe is full, one result leaves on every cycle. Without overlap, three instructions would need twelve cycles; with overlap, five need eight.

A four-slot prefetch queue sits ahead of the fetch stage. It reads sequential words from instruction memory on its own, so the fetch rate keeps up with the rate the pipe consumes them. The operand stage reads data memory with a one-cycle latency, using the address field of the instruction. Execute writes the register file and presents the result together with a valid flag.

A stall input freezes the whole pipe. Decode waits on its own when a source register is still owed by the instruction one stage ahead.

Top module: `ovl_pipe4`

## Requirements
- R1: While reset is held and after it is released, `res_valid` stays 0 until the first instruction completes. All four registers read as zero after reset.
- R2: An instruction is 16 bits wide:
  - bits [15:14] hold the opcode and bits [13:12] the destination register;
  - bits [11:10] hold the first source and bits [9:8] the second source;
  - bits [7:0] hold a data address.
- R2 (continued): The opcodes are:
  - 0: dest = src1 + src2;
  - 1: dest = src1 - src2;
  - 2: dest = src1 + dmem[addr];
  - 3: dest = dmem[addr].
- R2 (continued): Arithmetic wraps at the data width. Every completed instruction writes its destination register and shows the destination and value on `res_rd` and `res_data`.
- R3: The stages run in the order fetch, decode, operand read, execute. After reset is released and no stall is applied, the first result is valid in the cycle after the sixth rising edge. Two edges go to prefetch and four to the pipe.
- R4: A stream with no register dependences completes one instruction per cycle, in program order.
- R5: The prefetch queue holds 4 words and reads instruction memory from address 0 upward.
  - It raises `imem_en` only when a returned word is sure to fit.
  - Read data is expected on the cycle after the request.
  - When the queue is empty, fetch takes in a bubble.
- R6: Opcodes 2 and 3 raise `dmem_en` with `dmem_addr` equal to bits [7:0]. The data is taken one cycle later. The bench memory holds `dmem_rdata` while `dmem_en` is low.
- R7: A hazard exists when a source register is the destination of the instruction one stage ahead.
  - The younger instruction then waits one cycle, and a single bubble separates the two results.
  - A dependence on an instruction two or more ahead costs no cycle.
- R8: While `stall` is high at a rising edge, no stage moves and no register is written. `res_valid` is 0 after that edge. Program order and values are unchanged by any stall pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freezes every pipeline stage |
| imem_en | output | 1 | Instruction memory read request |
| imem_addr | output | IAW | Instruction word address |
| imem_rdata | input | 16 | Instruction word, one cycle after request |
| dmem_en | output | 1 | Data memory read request |
| dmem_addr | output | 8 | Data word address |
| dmem_rdata | input | DW | Data word, one cycle after request, held otherwise |
| res_valid | output | 1 | An instruction completed on the last edge |
| res_rd | output | 2 | Destination register of that instruction |
| res_data | output | DW | Value written |

## Verification
A run of independent loads shows the fill latency and the one-per-cycle rate, and tells a true overlap apart from a serial machine. Chains that depend at distance one, and chains that depend at distance two, separate a correct hazard check from one that stalls too often or too rarely. A sweep through all 256 combinations of opcode and register fields, first free and then under random stall, is compared value by value with an arithmetic model. That sweep exposes wrong operand routing, lost or repeated instructions, and results that leak out during a freeze.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
    localparam int INSTR_W = 16;
    localparam int RIDX_W  = 2;
    localparam int NREG    = 1 << RIDX_W;
    localparam int DADDR_W = 8;

    typedef enum logic [1:0] {
        OP_ADD   = 2'd0,
        OP_SUB   = 2'd1,
        OP_LDADD = 2'd2,
        OP_LD    = 2'd3
    } op_e;

    typedef struct packed {
        op_e                op;
        logic [RIDX_W-1:0]  rd;
        logic [RIDX_W-1:0]  rs1;
        logic [RIDX_W-1:0]  rs2;
        logic [DADDR_W-1:0] addr;
    } instr_t;

    function automatic logic reads_src1(op_e op);
        return op != OP_LD;
    endfunction

    function automatic logic reads_src2(op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

    function automatic logic reads_mem(op_e op);
        return (op == OP_LDADD) || (op == OP_LD);
    endfunction
endpackage

// File: rtl/ovl_ibuf.sv
module ovl_ibuf
    import ovl_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               imem_en,
    output logic [AW-1:0]      imem_addr,
    input  logic [INSTR_W-1:0] imem_rdata,
    input  logic               pop,
    output logic               empty,
    output instr_t             head
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][INSTR_W-1:0] slot;
        logic [PW-1:0]                 wp;
        logic [PW-1:0]                 rp;
        logic [CW-1:0]                 cnt;
        logic                          pend;
        logic [AW-1:0]                 pc;
    } ib_t;

    ib_t q, d;
    logic issue;

    always_comb begin
        d     = q;
        issue = (32'(q.cnt) + 32'(q.pend)) < DEPTH;
        if (q.pend) begin
            d.slot[q.wp] = imem_rdata;
            d.wp = (32'(q.wp) == DEPTH - 1) ? '0 : q.wp + 1'b1;
        end
        if (pop) begin
            d.rp = (32'(q.rp) == DEPTH - 1) ? '0 : q.rp + 1'b1;
        end
        d.cnt  = q.cnt + CW'(q.pend) - CW'(pop);
        d.pend = issue;
        d.pc   = q.pc + AW'(issue);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign imem_en   = issue;
    assign imem_addr = q.pc;
    assign empty     = (q.cnt == '0);
    assign head      = instr_t'(q.slot[q.rp]);

    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (q.cnt != '0));
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        q.pend |-> ((32'(q.cnt) < DEPTH) || pop));
endmodule

// File: rtl/ovl_rf.sv
module ovl_rf #(
    parameter int DW   = 16,
    parameter int NREG = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] wa,
    input  logic [DW-1:0]           wd,
    input  logic [$clog2(NREG)-1:0] ra1,
    input  logic [$clog2(NREG)-1:0] ra2,
    output logic [DW-1:0]           rd1,
    output logic [DW-1:0]           rd2
);
    logic [NREG-1:0][DW-1:0] r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (we) r_d[wa] = wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd1 = r_q[ra1];
    assign rd2 = r_q[ra2];

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (r_q[$past(wa)] == $past(wd)));
endmodule

// File: rtl/ovl_pipe4.sv
module ovl_pipe4
    import ovl_pkg::*;
#(
    parameter int DW        = 16,
    parameter int IAW       = 8,
    parameter int BUF_DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stall,
    output logic               imem_en,
    output logic [IAW-1:0]     imem_addr,
    input  logic [INSTR_W-1:0] imem_rdata,
    output logic               dmem_en,
    output logic [DADDR_W-1:0] dmem_addr,
    input  logic [DW-1:0]      dmem_rdata,
    output logic               res_valid,
    output logic [RIDX_W-1:0]  res_rd,
    output logic [DW-1:0]      res_data
);
    typedef struct packed {
        logic   v;
        instr_t ins;
    } fs_t;

    typedef struct packed {
        logic               v;
        op_e                op;
        logic [RIDX_W-1:0]  rd;
        logic [RIDX_W-1:0]  rs1;
        logic [RIDX_W-1:0]  rs2;
        logic [DADDR_W-1:0] addr;
    } ds_t;

    typedef struct packed {
        logic              v;
        op_e               op;
        logic [RIDX_W-1:0] rd;
        logic [DW-1:0]     a;
        logic [DW-1:0]     b;
    } os_t;

    typedef struct packed {
        logic              v;
        logic [RIDX_W-1:0] rd;
        logic [DW-1:0]     data;
    } rs_t;

    typedef struct packed {
        fs_t f;
        ds_t d;
        os_t o;
        rs_t r;
    } pipe_t;

    pipe_t  q, d;
    logic   hz, pop, empty, wr_en;
    instr_t head;
    logic [DW-1:0] rd1, rd2, ex_val;

    ovl_ibuf #(.DEPTH(BUF_DEPTH), .AW(IAW)) i_ibuf (
        .clk(clk), .rst_n(rst_n),
        .imem_en(imem_en), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .pop(pop), .empty(empty), .head(head)
    );

    ovl_rf #(.DW(DW), .NREG(NREG)) i_rf (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en), .wa(q.o.rd), .wd(ex_val),
        .ra1(q.d.rs1), .ra2(q.d.rs2), .rd1(rd1), .rd2(rd2)
    );

    always_comb begin
        hz = q.d.v && q.o.v &&
             ((reads_src1(q.d.op) && (q.o.rd == q.d.rs1)) ||
              (reads_src2(q.d.op) && (q.o.rd == q.d.rs2)));

        unique case (q.o.op)
            OP_ADD:   ex_val = q.o.a + q.o.b;
            OP_SUB:   ex_val = q.o.a - q.o.b;
            OP_LDADD: ex_val = q.o.a + dmem_rdata;
            default:  ex_val = dmem_rdata;
        endcase

        wr_en     = !stall && q.o.v;
        pop       = !stall && !hz && !empty;
        dmem_en   = !stall && !hz && q.d.v && reads_mem(q.d.op);
        dmem_addr = q.d.addr;

        d = q;
        if (stall) begin
            d.r.v = 1'b0;
        end else begin
            d.r = '{v: q.o.v, rd: q.o.rd, data: ex_val};
            if (hz) begin
                d.o.v = 1'b0;
            end else begin
                d.o = '{v: q.d.v, op: q.d.op, rd: q.d.rd, a: rd1, b: rd2};
                d.d = '{v: q.f.v, op: q.f.ins.op, rd: q.f.ins.rd,
                        rs1: q.f.ins.rs1, rs2: q.f.ins.rs2, addr: q.f.ins.addr};
                d.f = pop ? '{v: 1'b1, ins: head} : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign res_valid = q.r.v;
    assign res_rd    = q.r.rd;
    assign res_data  = q.r.data;

    a_r8_stall_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(q.f) && $stable(q.d) && $stable(q.o)));
    a_r8_no_result_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !res_valid);
    a_r7_bubble_on_hazard: assert property (@(posedge clk) disable iff (!rst_n)
        (hz && !stall) |=> (!q.o.v && $stable(q.d)));
    a_r6_dmem_for_mem_ops: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_en |-> (q.d.v && reads_mem(q.d.op)));
endmodule

// File: tb/test_ovl_pipe4.sv
module test_ovl_pipe4;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic        imem_en, dmem_en, res_valid;
    logic [7:0]  imem_addr, dmem_addr;
    logic [15:0] imem_rdata = '0;
    logic [15:0] dmem_rdata = '0;
    logic [1:0]  res_rd;
    logic [15:0] res_data;

    logic [15:0] imem [256];
    logic [15:0] dmem [256];
    logic [15:0] mr [4];
    int pc, cyc, base, nres, total, fails;
    int rc [0:511];

    always #(CLK_NS/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (imem_en) imem_rdata <= imem[imem_addr];
        if (dmem_en) dmem_rdata <= dmem[dmem_addr];
    end

    ovl_pipe4 i_ovl_pipe4 (
        .clk(clk), .rst_n(rst_n), .stall(stall),
        .imem_en(imem_en), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_en(dmem_en), .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata),
        .res_valid(res_valid), .res_rd(res_rd), .res_data(res_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        stall = 1'b0;
        repeat (3) @(negedge clk);
        check(res_valid == 1'b0, "R1 reset res_valid", int'(res_valid), 0);
        rst_n = 1'b1;
        base = cyc;
        for (int i = 0; i < 4; i++) mr[i] = '0;
        pc = 0;
    endtask

    task automatic model_step(output logic [1:0] erd, output logic [15:0] edat);
        logic [15:0] w, a, b, m;
        w = imem[pc];
        pc = (pc + 1) % 256;
        a = mr[w[11:10]];
        b = mr[w[9:8]];
        m = dmem[w[7:0]];
        case (w[15:14])
            2'd0:    edat = a + b;
            2'd1:    edat = a - b;
            2'd2:    edat = a + m;
            default: edat = m;
        endcase
        erd = w[13:12];
        mr[erd] = edat;
    endtask

    task automatic run(input int nwant, input bit use_stall, input string tag);
        int waited = 0;
        logic [1:0]  erd;
        logic [15:0] edat;
        nres = 0;
        while (nres < nwant) begin
            @(negedge clk);
            waited++;
            if (waited > 5000) begin
                check(1'b0, "watchdog", nres, nwant);
                break;
            end
            if (stall)
                check(res_valid == 1'b0, "R8 no result after stalled edge", int'(res_valid), 0);
            if (res_valid) begin
                model_step(erd, edat);
                check(res_rd == erd, {tag, " dest"}, int'(res_rd), int'(erd));
                check(res_data == edat, {tag, " value"}, int'(res_data), int'(edat));
                rc[nres] = cyc - base;
                nres++;
            end
            stall = use_stall ? (($urandom % 4) == 0) : 1'b0;
        end
        stall = 1'b0;
    endtask

    initial begin
        cyc = 0; total = 0; fails = 0;
        for (int i = 0; i < 256; i++) dmem[i] = 16'(i * 37 + 11);

        // R3 R4 R5 R6: independent loads
        for (int i = 0; i < 256; i++) imem[i] = {2'd3, 2'(i), 4'd0, 8'(i * 7)};
        do_reset();
        run(24, 1'b0, "R6 load");
        check(rc[0] == 6, "R3 first result cycle", rc[0], 6);
        for (int k = 1; k < 24; k++)
            check(rc[k] - rc[k-1] == 1, "R4 one per cycle", rc[k] - rc[k-1], 1);

        // R7: dependence at distance one
        for (int i = 0; i < 256; i++) imem[i] = {2'd2, 2'd1, 2'd1, 2'd0, 8'(i)};
        do_reset();
        run(16, 1'b0, "R7 chain1");
        for (int k = 1; k < 16; k++)
            check(rc[k] - rc[k-1] == 2, "R7 one bubble", rc[k] - rc[k-1], 2);

        // R7: dependence at distance two
        for (int i = 0; i < 256; i++)
            imem[i] = {2'd2, 2'(i % 2 + 1), 2'(i % 2 + 1), 2'd0, 8'(i)};
        do_reset();
        run(16, 1'b0, "R7 chain2");
        for (int k = 1; k < 16; k++)
            check(rc[k] - rc[k-1] == 1, "R7 no bubble", rc[k] - rc[k-1], 1);

        // R1 R2: sweep of all opcode and register fields
        for (int i = 0; i < 256; i++) imem[i] = {8'(i), 8'(i * 5 + 3)};
        do_reset();
        run(1, 1'b0, "R1 zero registers");
        run(299, 1'b0, "R2 sweep");

        // R8: same sweep under random stall
        do_reset();
        run(300, 1'b1, "R8 stalled sweep");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule